// File: doc/BRIEF.md
# Serial DAC write controller

This block takes sample words from a host over a valid/ready handshake and sends each one to a single external voltage-output converter. It uses a three-wire serial link: an active-low select, a serial clock and a data line. It can also drive an active-low load strobe that moves the shifted word into the converter's output register. All serial timing comes from the system clock. Every minimum interval is given in nanoseconds as a parameter and rounded up to whole system-clock cycles, with a floor of one cycle.

A frame runs in a fixed order:
1. The select goes low with the leading bit already on the data line.
2. Sixteen clock pulses shift the word out, most significant bit first.
3. A tail interval holds the select low after the last pulse, and then the select rises.
4. Unless the strobe is configured as tied low, the controller waits a setup interval and then pulses the strobe low for a fixed width.
5. A final idle gap completes the frame.

The host sees ready only while the controller is idle, so one word is in flight at a time.

Top module: `dac_serial_writer`

## Requirements
- R1: Each frame carries exactly 16 bits, most significant bit first, and the word latched by the converter equals the word accepted from the host.
- R2: The serial clock idles low and pulses only while the select is low. Each high phase and each low phase lasts at least 20 ns, and each clock period lasts at least 40 ns.
- R3: The data line changes only while the serial clock is low. It is stable at least 15 ns before every rising clock edge.
- R4: The select falls while the clock is low, at least 10 ns before the first rising clock edge. It stays low at least 20 ns after the last rising edge.
- R5: The select stays high at least 30 ns between consecutive frames.
- R6: When the strobe is not tied low, it falls only while the select is high and at least 30 ns after the select rises, and each low pulse lasts at least 30 ns.
- R7: With LOAD_TIED_LOW set to 1, the strobe is low at all times out of reset, and the word still reaches the converter when the select rises.
- R8: in_ready is high only while the controller is idle. It drops in the cycle after a word is accepted on in_valid and in_ready. It stays low until the strobe pulse and the idle gap have both finished. in_valid while in_ready is low has no effect.
- R9: While reset is held, the select is high, the clock is low, the strobe is high and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Controller is idle and will accept a word |
| in_data | input | DATA_W | Word to send |
| dac_cs_n | output | 1 | Active-low converter select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data to the converter |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
Errors in the bit counter or the shift register show at the ports within one frame. The converter model would then latch a frame with the wrong bit count or the wrong word at the next select rise. A phase timer that ends too early shortens a clock phase, a setup interval, the strobe pulse or the idle gap. That interval is measured at its closing edge, so the error is seen in the same frame. A sequencer that skips or repeats a state either leaves in_ready high while the select or strobe is active, or adds or drops a frame. The bench's expected-word queue then fails to line up at the next strobe.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_LD_WAIT,
        ST_LD_PULSE,
        ST_GAP
    } wr_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic ldac_n;
    } link_pins_t;

    // Minimum interval in ns -> system-clock cycles, rounded up, at least 1
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dac_wr_shifter.sv
module dac_wr_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             shift,
    output logic             msb
);
    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (load)
            sreg <= load_word;
        else if (shift)
            sreg <= {sreg[WIDTH-2:0], 1'b0};
    end

    assign msb = sreg[WIDTH-1];
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
    import dac_wr_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned TW       = 4,
    parameter int unsigned C_LEAD   = 1,
    parameter int unsigned C_HI     = 1,
    parameter int unsigned C_LO     = 1,
    parameter int unsigned C_TAIL   = 1,
    parameter int unsigned C_LDS    = 2,
    parameter int unsigned C_LDW    = 2,
    parameter int unsigned C_GAP    = 2,
    parameter bit          TIED_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          tmr_done,
    output logic          in_ready,
    output logic          accept,
    output logic          shift,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output link_pins_t    pins
);
    localparam int unsigned BW = $clog2(WIDTH);

    wr_state_e     st, st_n;
    logic [BW-1:0] bits_left;

    always_comb begin
        st_n     = st;
        accept   = 1'b0;
        shift    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: if (in_valid && !rst) begin
                accept   = 1'b1;
                st_n     = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_LEAD - 1);
            end
            ST_LEAD: if (tmr_done) begin
                st_n     = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_HI - 1);
            end
            ST_HIGH: if (tmr_done) begin
                tmr_load = 1'b1;
                if (bits_left == '0) begin
                    st_n    = ST_TAIL;
                    tmr_val = TW'(C_TAIL - 1);
                end else begin
                    st_n    = ST_LOW;
                    shift   = 1'b1;
                    tmr_val = TW'(C_LO - 1);
                end
            end
            ST_LOW: if (tmr_done) begin
                st_n     = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_HI - 1);
            end
            ST_TAIL: if (tmr_done) begin
                tmr_load = 1'b1;
                if (TIED_LOW) begin
                    st_n    = ST_GAP;
                    tmr_val = TW'(C_GAP - 1);
                end else begin
                    st_n    = ST_LD_WAIT;
                    tmr_val = TW'(C_LDS - 1);
                end
            end
            ST_LD_WAIT: if (tmr_done) begin
                st_n     = ST_LD_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_LDW - 1);
            end
            ST_LD_PULSE: if (tmr_done) begin
                st_n     = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(C_GAP - 1);
            end
            ST_GAP: if (tmr_done) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bits_left <= '0;
        end else begin
            st <= st_n;
            if (accept)
                bits_left <= BW'(WIDTH - 1);
            else if (shift)
                bits_left <= bits_left - 1'b1;
        end
    end

    assign in_ready    = (st == ST_IDLE) && !rst;
    assign pins.cs_n   = !(st inside {ST_LEAD, ST_HIGH, ST_LOW, ST_TAIL});
    assign pins.sclk   = (st == ST_HIGH);
    assign pins.ldac_n = TIED_LOW ? 1'b0 : (st != ST_LD_PULSE);
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
    import dac_wr_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_NS        = 20,
    parameter int unsigned SCLK_HI_NS    = 20,
    parameter int unsigned SCLK_LO_NS    = 20,
    parameter int unsigned SCLK_PER_NS   = 40,
    parameter int unsigned CS_SETUP_NS   = 10,
    parameter int unsigned DATA_SETUP_NS = 15,
    parameter int unsigned CS_HOLD_NS    = 20,
    parameter int unsigned CS_IDLE_NS    = 30,
    parameter int unsigned LD_SETUP_NS   = 30,
    parameter int unsigned LD_WIDTH_NS   = 30,
    parameter bit          LOAD_TIED_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              dac_ldac_n
);
    localparam int unsigned C_HI   = ns_to_cyc(SCLK_HI_NS, CLK_NS);
    localparam int unsigned C_LO   = max2(max2(ns_to_cyc(SCLK_LO_NS, CLK_NS),
                                               ns_to_cyc(DATA_SETUP_NS, CLK_NS)),
                                          max2(ns_to_cyc(SCLK_PER_NS, CLK_NS), C_HI + 1) - C_HI);
    localparam int unsigned C_LEAD = max2(ns_to_cyc(CS_SETUP_NS, CLK_NS),
                                          ns_to_cyc(DATA_SETUP_NS, CLK_NS));
    localparam int unsigned C_TAIL = ns_to_cyc(CS_HOLD_NS, CLK_NS);
    localparam int unsigned C_LDS  = ns_to_cyc(LD_SETUP_NS, CLK_NS);
    localparam int unsigned C_LDW  = ns_to_cyc(LD_WIDTH_NS, CLK_NS);
    localparam int unsigned C_GAP  = ns_to_cyc(CS_IDLE_NS, CLK_NS);
    localparam int unsigned C_MAX  = max2(max2(max2(C_HI, C_LO), max2(C_LEAD, C_TAIL)),
                                          max2(max2(C_LDS, C_LDW), C_GAP));
    localparam int unsigned TW     = $clog2(C_MAX + 1);

    logic          accept, shift, tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    link_pins_t    pins;

    dac_wr_seq #(
        .WIDTH(DATA_W), .TW(TW), .C_LEAD(C_LEAD), .C_HI(C_HI), .C_LO(C_LO),
        .C_TAIL(C_TAIL), .C_LDS(C_LDS), .C_LDW(C_LDW), .C_GAP(C_GAP),
        .TIED_LOW(LOAD_TIED_LOW)
    ) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .tmr_done(tmr_done),
        .in_ready(in_ready), .accept(accept), .shift(shift),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .pins(pins)
    );

    dac_wr_timer #(.CNT_W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    dac_wr_shifter #(.WIDTH(DATA_W)) u_shf (
        .clk(clk), .rst(rst), .load(accept), .load_word(in_data),
        .shift(shift), .msb(dac_sdo)
    );

    assign dac_cs_n   = pins.cs_n;
    assign dac_sclk   = pins.sclk;
    assign dac_ldac_n = pins.ldac_n;
endmodule

// File: rtl/dac_serial_writer_chk.sv
module dac_serial_writer_chk #(
    parameter bit TIED = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic dac_cs_n,
    input logic dac_sclk,
    input logic dac_sdo,
    input logic dac_ldac_n
);
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !dac_cs_n |-> !in_ready);

    a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r2_clock_only_in_frame: assert property (@(posedge clk) disable iff (rst)
        dac_sclk |-> !dac_cs_n);

    a_r3_data_still_while_high: assert property (@(posedge clk) disable iff (rst)
        dac_sclk |-> $stable(dac_sdo));

    a_r4_select_falls_clock_low: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_cs_n) |-> !dac_sclk);

    a_r6_load_while_deselected: assert property (@(posedge clk) disable iff (rst)
        (!TIED && !dac_ldac_n) |-> (dac_cs_n && !in_ready));

    a_r6_load_after_release: assert property (@(posedge clk) disable iff (rst)
        (!TIED && $fell(dac_ldac_n)) |-> $past(dac_cs_n));

    a_r7_tied_low: assert property (@(posedge clk) disable iff (rst)
        TIED |-> !dac_ldac_n);
endmodule

bind dac_serial_writer dac_serial_writer_chk #(.TIED(LOAD_TIED_LOW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .dac_ldac_n(dac_ldac_n)
);

// File: tb/dac_serial_writer_tb.sv
`timescale 1ns/1ps
module dac_serial_writer_tb;
    localparam real T_HI = 20.0, T_LO = 20.0, T_PER = 40.0, T_CSS = 10.0;
    localparam real T_DS = 15.0, T_CSH = 20.0, T_IDLE = 30.0, T_LDS = 30.0, T_LDW = 30.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_data  = '0;
    logic        cs_n, sclk, sdo, ldac_n;

    logic        tl_valid = 1'b0, tl_ready;
    logic [15:0] tl_data  = '0;
    logic        tl_cs_n, tl_sclk, tl_sdo, tl_ldac_n;

    dac_serial_writer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .dac_cs_n(cs_n), .dac_sclk(sclk), .dac_sdo(sdo), .dac_ldac_n(ldac_n)
    );

    dac_serial_writer #(.LOAD_TIED_LOW(1'b1)) u_dut_tl (
        .clk(clk), .rst(rst), .in_valid(tl_valid), .in_ready(tl_ready), .in_data(tl_data),
        .dac_cs_n(tl_cs_n), .dac_sclk(tl_sclk), .dac_sdo(tl_sdo), .dac_ldac_n(tl_ldac_n)
    );

    int          n_cmp = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    bit          armed = 1'b0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_min(input real got, input real lim, input string req);
        n_cmp++;
        if (got < lim) begin
            n_bad++;
            $display("FAIL %s actual=%0.1f ns expected>=%0.1f ns", req, got, lim);
        end
    endtask

    // ---------------- converter model and interval monitor ----------------
    real         t_cs_fall = 0.0, t_cs_rise = -1.0e6, t_rise = -1.0e6, t_fall = -1.0e6;
    real         t_sdo = -1.0e6, t_ld_fall = 0.0;
    int          bitcnt = 0;
    bit          first = 1'b0;
    logic [15:0] sr = '0, in_reg = '0, dac_out = '0;
    int          bad_ready = 0;

    always @(negedge cs_n) if (armed) begin
        check_min($realtime - t_cs_rise, T_IDLE, "R5 select idle gap");
        check(!sclk, "R4 clock low at select fall", sclk, 0);
        t_cs_fall = $realtime;
        bitcnt = 0;
        first = 1'b1;
    end

    always @(posedge sclk) if (armed) begin
        check(!cs_n, "R2 clock only while selected", cs_n, 0);
        if (first)
            check_min($realtime - t_cs_fall, T_CSS, "R4 select setup");
        else begin
            check_min($realtime - t_rise, T_PER, "R2 clock period");
            check_min($realtime - t_fall, T_LO, "R2 clock low");
        end
        check_min($realtime - t_sdo, T_DS, "R3 data setup");
        sr = {sr[14:0], sdo};
        bitcnt++;
        t_rise = $realtime;
        first = 1'b0;
    end

    always @(negedge sclk) if (armed) begin
        check_min($realtime - t_rise, T_HI, "R2 clock high");
        t_fall = $realtime;
    end

    always @(sdo) if (armed) begin
        t_sdo = $realtime;
        if (!cs_n)
            check_min($realtime - t_rise, T_HI, "R3 data moved during high phase");
    end

    always @(posedge cs_n) if (armed) begin
        check_min($realtime - t_rise, T_CSH, "R4 select hold");
        check(bitcnt == 16, "R1 bits per frame", bitcnt, 16);
        in_reg = sr;
        t_cs_rise = $realtime;
    end

    always @(negedge ldac_n) if (armed) begin
        check(cs_n, "R6 strobe while deselected", cs_n, 1);
        check_min($realtime - t_cs_rise, T_LDS, "R6 strobe setup");
        t_ld_fall = $realtime;
        dac_out = in_reg;
        if (exp_q.size() == 0)
            check(1'b0, "R8 unexpected frame", dac_out, 0);
        else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(dac_out == e, "R1 latched word", dac_out, e);
        end
    end

    always @(posedge ldac_n) if (armed)
        check_min($realtime - t_ld_fall, T_LDW, "R6 strobe width");

    always @(negedge clk) if (armed && in_ready && (!cs_n || !ldac_n)) bad_ready++;

    // tied-low instance model
    logic [15:0] tl_sr = '0, tl_out = '0;
    int          tl_frames = 0, tl_ld_high = 0;
    always @(posedge tl_sclk) if (armed) tl_sr = {tl_sr[14:0], tl_sdo};
    always @(posedge tl_cs_n) if (armed) begin
        tl_out = tl_sr;
        tl_frames++;
    end
    always @(negedge clk) if (armed && tl_ldac_n) tl_ld_high++;

    // ---------------- driver ----------------
    task automatic send(input logic [15:0] w);
        do @(negedge clk); while (!in_ready);
        in_valid = 1'b1;
        in_data  = w;
        exp_q.push_back(w);
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R8 ready drops after accept", in_ready, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R9: levels while reset is held
        check(cs_n == 1'b1, "R9 select high in reset", cs_n, 1);
        check(sclk == 1'b0, "R9 clock low in reset", sclk, 0);
        check(ldac_n == 1'b1, "R9 strobe high in reset", ldac_n, 1);
        check(in_ready == 1'b0, "R9 ready low in reset", in_ready, 0);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready when idle", in_ready, 1);

        // R1: distinct patterns, back to back
        send(16'h8000);
        send(16'h0001);
        send(16'hFFFF);
        send(16'h0000);
        send(16'hA5C3);
        send(16'h5A3C);
        lfsr = 16'hACE1;
        for (int i = 0; i < 6; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr);
        end

        // R8: valid held while busy must not start a frame
        send(16'h1234);
        in_valid = 1'b1;
        in_data  = 16'hDEAD;
        while (ldac_n) begin
            @(negedge clk);
            check(!in_ready, "R8 ready low while busy", in_ready, 0);
        end
        in_valid = 1'b0;
        do @(negedge clk); while (!in_ready);
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1, "R8 no frame from ignored valid", cs_n, 1);
        send(16'h4321);
        do @(negedge clk); while (!in_ready);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all frames latched", exp_q.size(), 0);
        check(bad_ready == 0, "R8 ready while busy", bad_ready, 0);

        // R7: tied-low variant
        tl_valid = 1'b1;
        tl_data  = 16'hC0DE;
        @(negedge clk);
        tl_valid = 1'b0;
        do @(negedge clk); while (!tl_ready);
        check(tl_frames == 1, "R7 one frame sent", tl_frames, 1);
        check(tl_out == 16'hC0DE, "R7 word at select rise", tl_out, 16'hC0DE);
        check(tl_ld_high == 0, "R7 strobe held low", tl_ld_high, 0);
        finish_run();
    end
endmodule